// File: doc/BRIEF.md
# Scalar Bitfield Extract and Mask Unit

This unit handles the bitfield operations of a scalar datapath on 32-bit or 64-bit words. Three operations share one result path: an unsigned field extract, a sign-extending field extract, and a contiguous-mask builder. A 2-bit operation select and a width select choose the form. The data operand `src_a` is 64 bits wide and the control operand `src_b` is 32 bits wide. Each result is registered and comes with a new value for the scalar condition flag, plus a write-enable that tells the register stage whether that flag is to be updated.

For the extract forms, the field's bit offset and bit length are packed together in `src_b`, and `src_a` holds the word the field is taken from. For the mask form, `src_a` supplies the run length and `src_b` supplies the starting bit. The mask form never requests a flag update, so code that builds masks keeps a flag produced by earlier compare logic.

Operands enter through a valid/ready handshake, and results leave through one. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the outputs one cycle later, with `out_valid` high. The unit holds one result. `in_ready` is high when the output register is empty or when the result in it is being taken in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the outputs stay frozen and no new operand is accepted.

Top module: `bitfield_unit`

## Requirements
- R1: An operand accepted at one rising edge produces `out_valid` high after that same edge. `out_valid` falls after an edge where `out_ready` is high and no operand is accepted. `out_valid` is low after reset.
- R2: The operation encodings of `op` are: 0 unsigned extract, 1 signed extract, 2 mask build, 3 reserved. The reserved code gives a zero result and a flag write-enable of 0.
- R3: For extracts, the field length is `src_b[22:16]` (7 bits). The offset is `src_b[4:0]` when `wide`=0 and `src_b[5:0]` when `wide`=1. All other `src_b` bits have no effect.
- R4: An extract with field length 0 gives result 0.
- R5: When offset + length is below the word width (32 or 64), an extract returns the `length` bits that start at `offset`, moved down to bit 0.
- R6: Signed extract copies the top bit of the field into every result bit above the field, up to the word width.
- R7: When offset + length is at least the word width, the extract returns the word shifted right by the offset. The shift is logical for unsigned extract and arithmetic for signed extract.
- R8: Both extract forms give `flag_we`=1, with `flag_out`=1 exactly when the result is non-zero.
- R9: Mask build returns a run of L one-bits starting at bit S. L is taken from `src_a` and S from `src_b`, each reduced to its low 5 bits (`wide`=0) or low 6 bits (`wide`=1). Bits pushed past the word width are dropped.
- R10: Mask build gives `flag_we`=0 and `flag_out`=0.
- R11: With `wide`=0, result bits 63:32 are zero, and `src_a[63:32]` has no effect on the result.
- R12: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and the result and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand bundle present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| op | input | 2 | Operation select (see R2) |
| wide | input | 1 | 1 selects 64-bit words, 0 selects 32-bit words |
| src_a | input | 64 | Data word (extract) or run length (mask) |
| src_b | input | 32 | Packed offset/length (extract) or start bit (mask) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 64 | Operation result |
| flag_out | output | 1 | New condition flag value |
| flag_we | output | 1 | Condition flag update request |

## Verification
The properties assume the following about the inputs. Reset is held low for at least one clock edge. Any operand bundle that is offered stays stable only if the producer chooses to hold it; the properties check what the unit captures, not what the producer holds. `op` and `wide` are never X while `in_valid` is high. The stimulus meets these assumptions: inputs are driven on falling edges only, reset stays asserted for several cycles with `in_valid` low, and every transaction presents fully defined operands. One back-pressure sequence holds its bundle steady while `in_ready` is low.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [1:0] {
    BF_UEXT = 2'd0,
    BF_SEXT = 2'd1,
    BF_MASK = 2'd2,
    BF_RSVD = 2'd3
  } bf_op_e;

endpackage

// File: rtl/bfu_extract.sv
// Field extraction for the unsigned and signed forms.
module bfu_extract #(
  parameter int DATA_W  = 64,
  parameter int CTRL_W  = 32,
  parameter int LEN_LSB = 16,
  parameter int LEN_W   = 7
) (
  input  logic [DATA_W-1:0] src,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              is_signed,
  input  logic              wide,
  output logic [DATA_W-1:0] value
);
  localparam int HALF  = DATA_W / 2;
  localparam int OFF_W = $clog2(DATA_W);
  localparam int SUM_W = LEN_W + 1;

  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  len;
  logic [SUM_W-1:0]  reach;
  logic [SUM_W-1:0]  limit;
  logic [DATA_W-1:0] widened;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;
  logic              top_bit;

  always_comb begin
    off   = wide ? ctrl[OFF_W-1:0] : {1'b0, ctrl[OFF_W-2:0]};
    len   = ctrl[LEN_LSB +: LEN_W];
    reach = SUM_W'(off) + SUM_W'(len);
    limit = wide ? SUM_W'(DATA_W) : SUM_W'(HALF);

    // Narrow words are first widened so one shifter covers both sizes.
    if (wide)
      widened = src;
    else if (is_signed)
      widened = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
    else
      widened = {{HALF{1'b0}}, src[HALF-1:0]};

    if (is_signed)
      shifted = DATA_W'($signed(widened) >>> off);
    else
      shifted = widened >> off;

    keep    = '0;
    top_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      keep[i] = (i < int'(len));
      if (i + 1 == int'(len)) top_bit = shifted[i];
    end

    if (len == '0)
      value = '0;
    else if (reach < limit)
      value = (shifted & keep) | ((is_signed && top_bit) ? ~keep : '0);
    else
      value = shifted;

    if (!wide) value[DATA_W-1:HALF] = '0;
  end
endmodule

// File: rtl/bfu_mask.sv
// Contiguous mask builder: run length from one operand, start bit from the other.
module bfu_mask #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 32
) (
  input  logic [DATA_W-1:0] len_src,
  input  logic [CTRL_W-1:0] pos_src,
  input  logic              wide,
  output logic [DATA_W-1:0] value
);
  localparam int HALF  = DATA_W / 2;
  localparam int OFF_W = $clog2(DATA_W);

  logic [OFF_W-1:0]  run_len;
  logic [OFF_W-1:0]  start;
  logic [DATA_W-1:0] ones;

  always_comb begin
    run_len = wide ? len_src[OFF_W-1:0] : {1'b0, len_src[OFF_W-2:0]};
    start   = wide ? pos_src[OFF_W-1:0] : {1'b0, pos_src[OFF_W-2:0]};
    ones    = '0;
    for (int i = 0; i < DATA_W; i++) ones[i] = (i < int'(run_len));
    value = ones << start;
    if (!wide) value[DATA_W-1:HALF] = '0;
  end
endmodule

// File: rtl/bfu_out_stage.sv
// Single-entry output register with valid/ready on both sides.
module bfu_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] nxt_value,
  input  logic              nxt_flag,
  input  logic              nxt_we,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] value_q,
  output logic              flag_q,
  output logic              we_q
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      value_q   <= '0;
      flag_q    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        value_q   <= nxt_value;
        flag_q    <= nxt_flag;
        we_q      <= nxt_we;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W  = 64,
  parameter int CTRL_W  = 32,
  parameter int LEN_LSB = 16,
  parameter int LEN_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] src_a,
  input  logic [CTRL_W-1:0] src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              flag_out,
  output logic              flag_we
);
  import bfu_pkg::*;

  bf_op_e            op_sel;
  logic [DATA_W-1:0] ext_value;
  logic [DATA_W-1:0] mask_value;
  logic [DATA_W-1:0] nxt_value;
  logic              nxt_flag;
  logic              nxt_we;

  assign op_sel = bf_op_e'(op);

  bfu_extract #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W)
  ) u_extract (
    .src       (src_a),
    .ctrl      (src_b),
    .is_signed (op_sel == BF_SEXT),
    .wide      (wide),
    .value     (ext_value)
  );

  bfu_mask #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_mask (
    .len_src (src_a),
    .pos_src (src_b),
    .wide    (wide),
    .value   (mask_value)
  );

  always_comb begin
    unique case (op_sel)
      BF_UEXT, BF_SEXT: begin
        nxt_value = ext_value;
        nxt_flag  = |ext_value;
        nxt_we    = 1'b1;
      end
      BF_MASK: begin
        nxt_value = mask_value;
        nxt_flag  = 1'b0;
        nxt_we    = 1'b0;
      end
      default: begin
        nxt_value = '0;
        nxt_flag  = 1'b0;
        nxt_we    = 1'b0;
      end
    endcase
  end

  bfu_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .nxt_value (nxt_value),
    .nxt_flag  (nxt_flag),
    .nxt_we    (nxt_we),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .value_q   (result),
    .flag_q    (flag_out),
    .we_q      (flag_we)
  );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int DATA_W  = 64,
  parameter int CTRL_W  = 32,
  parameter int LEN_LSB = 16,
  parameter int LEN_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        op,
  input logic              wide,
  input logic [CTRL_W-1:0] src_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              flag_out,
  input logic              flag_we
);
  localparam int HALF = DATA_W / 2;

  logic accept;
  assign accept = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == 2'd3) |=> (result == '0 && !flag_we));

  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op[1] && src_b[LEN_LSB +: LEN_W] == '0) |=> (result == '0));

  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_we) |-> (flag_out == (result != '0)));

  p_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == 2'd2) |=> (!flag_we && !flag_out));

  p_narrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide) |=> (result[DATA_W-1:HALF] == '0));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_out)));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind bitfield_unit bfu_checker #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LEN_LSB(LEN_LSB), .LEN_W(LEN_W)
) u_bfu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .wide(wide), .src_b(src_b), .out_valid(out_valid),
  .out_ready(out_ready), .result(result), .flag_out(flag_out), .flag_we(flag_we)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic        wide;
    logic [63:0] a;
    logic [31:0] b;
    logic [63:0] exp;
    logic        ef;
    logic        ewe;
  } vec_t;

  // op: 0 unsigned extract, 1 signed extract, 2 mask build
  localparam vec_t VEC [NVEC] = '{
    // R5 unsigned field, offset 4 length 8
    '{8'd5,  2'd0, 1'b0, 64'h0000_0000_1234_5678, 32'h0008_0004, 64'h67, 1'b1, 1'b1},
    // R6 negative 4-bit field sign-extended to 32 bits
    '{8'd6,  2'd1, 1'b0, 64'h0000_0000_0000_00F0, 32'h0004_0004, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b1},
    // R7 logical shift once field reaches the top
    '{8'd7,  2'd0, 1'b0, 64'h0000_0000_F000_0000, 32'h0008_001C, 64'hF, 1'b1, 1'b1},
    // R7 arithmetic shift for the signed form
    '{8'd7,  2'd1, 1'b0, 64'h0000_0000_F000_0000, 32'h0008_001C, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b1},
    // R4 zero length, R8 flag clear
    '{8'd4,  2'd0, 1'b0, 64'h0000_0000_FFFF_FFFF, 32'h0000_0003, 64'h0, 1'b0, 1'b1},
    // R3 bit 31 of control ignored, 64-bit offset 32 length 16
    '{8'd3,  2'd0, 1'b1, 64'hFEDC_BA98_7654_3210, 32'h8010_0020, 64'hBA98, 1'b1, 1'b1},
    // R7 signed 64-bit, offset 56 length 8
    '{8'd7,  2'd1, 1'b1, 64'hFEDC_BA98_7654_3210, 32'h0008_0038, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b1},
    // R6 signed 64-bit, field 0xA9 at bit 36
    '{8'd6,  2'd1, 1'b1, 64'hFEDC_BA98_7654_3210, 32'h0008_0024, 64'hFFFF_FFFF_FFFF_FFA9, 1'b1, 1'b1},
    // R11 upper data ignored; R3 offset bit 5 ignored in narrow mode
    '{8'd11, 2'd0, 1'b0, 64'hAAAA_AAAA_0000_01E0, 32'h0004_0025, 64'hF, 1'b1, 1'b1},
    // R8 extracted field is zero
    '{8'd8,  2'd0, 1'b0, 64'h0000_0000_FFFF_00FF, 32'h0008_0008, 64'h0, 1'b0, 1'b1},
    // R9 narrow mask 8 ones at bit 4
    '{8'd9,  2'd2, 1'b0, 64'h8,                    32'h0000_0004, 64'hFF0, 1'b0, 1'b0},
    // R9 narrow mask with operand reduction and drop past bit 31
    '{8'd9,  2'd2, 1'b0, 64'h23,                   32'h0000_003E, 64'h0000_0000_C000_0000, 1'b0, 1'b0},
    // R9 wide mask 16 ones at bit 48
    '{8'd9,  2'd2, 1'b1, 64'h10,                   32'h0000_0030, 64'hFFFF_0000_0000_0000, 1'b0, 1'b0},
    // R10 wide mask of length 64 reduced to 0
    '{8'd10, 2'd2, 1'b1, 64'h40,                   32'h0000_0005, 64'h0, 1'b0, 1'b0},
    // R7 length 127 at offset 0 returns the whole word
    '{8'd7,  2'd0, 1'b1, 64'h8000_0000_0000_0001, 32'h007F_0000, 64'h8000_0000_0000_0001, 1'b1, 1'b1},
    // R7 signed offset 63 length 1
    '{8'd7,  2'd1, 1'b1, 64'h8000_0000_0000_0001, 32'h0001_003F, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'd0;
  logic        wide = 1'b0;
  logic [63:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        flag_out;
  logic        flag_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .wide(wide), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .flag_out(flag_out), .flag_we(flag_we)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operand at a falling edge; sample the result one edge later.
  task automatic send(input logic [1:0] o, input logic w, input logic [63:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; wide = w; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset flag_we", {63'd0, flag_we}, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      send(VEC[k].op, VEC[k].wide, VEC[k].a, VEC[k].b);
      checks++;
      if (out_valid !== 1'b1 || result !== VEC[k].exp ||
          flag_out !== VEC[k].ef || flag_we !== VEC[k].ewe) begin
        errors++;
        $display("FAIL R%0d vector %0d actual %h/%b/%b/%b expected %h/1/%b/%b",
                 VEC[k].req, k, result, out_valid, flag_out, flag_we,
                 VEC[k].exp, VEC[k].ef, VEC[k].ewe);
      end
    end

    // R2 reserved code
    send(2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0008_0000);
    check("R2 reserved result", result, 64'd0);
    check("R2 reserved flag_we", {63'd0, flag_we}, 64'd0);

    // R1 valid drops when nothing new is accepted
    @(negedge clk);
    check("R1 valid falls", {63'd0, out_valid}, 64'd0);

    // R12 back-pressure sequence
    @(negedge clk);
    out_ready = 1'b0;
    op = 2'd0; wide = 1'b0; src_a = 64'hFF; src_b = 32'h0004_0000; in_valid = 1'b1;
    @(negedge clk);
    check("R12 first result", result, 64'hF);
    op = 2'd2; wide = 1'b0; src_a = 64'h4; src_b = 32'h0000_0008;
    @(negedge clk);
    check("R12 in_ready low", {63'd0, in_ready}, 64'd0);
    check("R12 held result", result, 64'hF);
    check("R12 held flag", {63'd0, flag_out}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 second result", result, 64'hF00);
    check("R10 second flag_we", {63'd0, flag_we}, 64'd0);
    @(negedge clk);
    check("R1 empty after drain", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual hung expected finish");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule